// File: doc/BRIEF.md
# System Clock Source Switch and Bus Prescalers

This block chooses which of six clock sources drives the system clock and derives two slower clocks from it. The first is the core/bus clock, a divided copy of the system clock. The second is the peripheral clock, a divided copy of the core clock. Every clock is modelled as a one-cycle enable pulse in a single reference clock domain. Each source presents a tick input and a ready input. The block outputs the enable pulses for the system, core and peripheral clocks.

Software writes four fields, each through its own write strobe:
- the source request,
- the core divider code,
- the peripheral divider code,
- a one-bit choice of which internal RC acts as wake-up and backup clock.

Hardware reports which source is actually in use. A requested source becomes active only after it has been ready for a fixed number of consecutive reference cycles. The request falls back to the multi-speed internal RC when either of these happens:
- the device leaves a low-power mode;
- the external crystal is requested and its failure is flagged.

Divider changes are held pending and take effect only at the next output pulse of that divider.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the request field reads 0, the status reads 0, both divider readbacks read 0, the wake select reads 0, and both dividers pass every input tick (divide by 1).
- R2: Source codes are 0 multi-speed RC, 1 16 MHz RC, 2 external crystal, 3 PLL, 4 low-speed RC and 5 low-speed crystal. A request write of 0 to 5 is taken. A write of 6 or 7 leaves the request field unchanged.
- R3: The status field uses the same codes as the request field. It takes the requested code only after that source's ready input has been high for RDY_CYC consecutive cycles. With RDY_CYC = 4 and ready held high, the status changes on the fourth clock edge after the edge that stored the request. While ready is low, the status keeps its old value.
- R4: The system clock enable equals the tick input of the source shown in the status field.
- R5: A low-power exit pulse forces the request field to 0 on the next edge. This takes priority over a request written in the same cycle.
- R6: A crystal failure pulse forces the request field to 0 only while the request field holds 2. With any other request it has no effect.
- R7: The core divider code is 4 bits. Any code with bit 3 clear divides by 1. Codes 8 through 15 divide by 2, 4, 8, 16, 64, 128, 256 and 512.
- R8: The peripheral divider code is 3 bits and divides the core clock enable. Any code with bit 2 clear divides by 1. Codes 4 through 7 divide by 2, 4, 8 and 16.
- R9: A written divider code takes effect on that divider's next output pulse, and the readback shows the old code until then. The interval that is running when the write arrives keeps the old length.
- R10: A wake-select write is ignored while the failure monitor enable is high and code 2 is either requested or active. Otherwise the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 6 | Per-source clock pulses, indexed by source code |
| src_rdy | input | 6 | Per-source ready flags, indexed by source code |
| lp_exit | input | 1 | Pulse on exit from a low-power mode |
| xtal_fail | input | 1 | Pulse when external crystal failure is detected |
| mon_en | input | 1 | External oscillator failure monitor enabled |
| src_we | input | 1 | Write strobe for the source request |
| src_wdata | input | 3 | Requested source code |
| core_we | input | 1 | Write strobe for the core divider code |
| core_wdata | input | 4 | Core divider code |
| per_we | input | 1 | Write strobe for the peripheral divider code |
| per_wdata | input | 3 | Peripheral divider code |
| wk_we | input | 1 | Write strobe for the wake select |
| wk_wdata | input | 1 | Wake select: 0 multi-speed RC, 1 16 MHz RC |
| src_sel | output | 3 | Request field readback |
| src_act | output | 3 | Source in use (status) |
| core_div | output | 4 | Core divider code in effect |
| per_div | output | 3 | Peripheral divider code in effect |
| wk_sel | output | 1 | Wake select in effect |
| sys_en | output | 1 | System clock enable pulse |
| core_en | output | 1 | Core/bus clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |

## Verification
The bench measures the pulse interval for every divider code, including the jump from 16 to 64. A decoder that counted linearly, or that handled the peripheral codes with bit 2 clear wrongly, would show a wrong interval there. It writes a new divider code just after a pulse and checks two things: that the running interval keeps its old length, and that the readback changes only at that boundary. A block that applied the code at once would shorten the pulse or report the code early. It counts edges exactly around the ready qualification of the status. It checks that reserved codes, a crystal failure on a non-crystal request and a locked wake-select write all leave the visible fields untouched. It also checks that a wake-up event beats a request written in the same cycle.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned NSRC   = 6;
  localparam int unsigned SRC_W  = 3;
  localparam logic [2:0] SRC_MSI  = 3'd0;
  localparam logic [2:0] SRC_XTAL = 3'd2;

  // shift amount for the core divider: bit 3 clear -> /1, 8..11 -> /2../16, 12..15 -> /64../512
  function automatic logic [3:0] core_shift(input logic [3:0] code);
    if (!code[3])     return 4'd0;
    else if (!code[2]) return {2'b00, code[1:0]} + 4'd1;
    else               return {2'b00, code[1:0]} + 4'd6;
  endfunction

  // shift amount for the peripheral divider: bit 2 clear -> /1, 4..7 -> /2../16
  function automatic logic [3:0] per_shift(input logic [2:0] code);
    if (!code[2]) return 4'd0;
    else          return {2'b00, code[1:0]} + 4'd1;
  endfunction
endpackage

// File: rtl/sysclk_src_switch.sv
module sysclk_src_switch
  import sysclk_pkg::*;
#(
  parameter int unsigned RDY_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_rdy,
  input  logic             lp_exit,
  input  logic             xtal_fail,
  input  logic             mon_en,
  input  logic             src_we,
  input  logic [SRC_W-1:0] src_wdata,
  input  logic             wk_we,
  input  logic             wk_wdata,
  output logic [SRC_W-1:0] sel,
  output logic [SRC_W-1:0] act,
  output logic             wk
);
  localparam int unsigned RC_W = $clog2(RDY_CYC) + 1;

  logic [SRC_W-1:0] sel_d, act_d;
  logic [RC_W-1:0]  rcnt, rcnt_d;
  logic             wk_d;
  logic             force_msi, wk_lock, tgt_rdy;

  always_comb begin
    force_msi = lp_exit || (xtal_fail && (sel == SRC_XTAL));
    wk_lock   = mon_en && ((sel == SRC_XTAL) || (act == SRC_XTAL));
    tgt_rdy   = src_rdy[sel];

    sel_d = sel;
    if (force_msi)                             sel_d = SRC_MSI;
    else if (src_we && (src_wdata < SRC_W'(NSRC))) sel_d = src_wdata;

    act_d  = act;
    rcnt_d = rcnt;
    if ((sel_d != sel) || (sel == act) || !tgt_rdy) begin
      rcnt_d = '0;
    end else if (rcnt == RC_W'(RDY_CYC - 1)) begin
      rcnt_d = '0;
      act_d  = sel;
    end else begin
      rcnt_d = rcnt + RC_W'(1);
    end

    wk_d = wk;
    if (wk_we && !wk_lock) wk_d = wk_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= SRC_MSI;
      act  <= SRC_MSI;
      rcnt <= '0;
      wk   <= 1'b0;
    end else begin
      sel  <= sel_d;
      act  <= act_d;
      rcnt <= rcnt_d;
      wk   <= wk_d;
    end
  end

  p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel < SRC_W'(NSRC));
  p_act_from_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> (act == $past(sel)));
  p_wake_forces_msi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lp_exit) |-> (sel == SRC_MSI));
  p_fail_forces_msi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xtal_fail && (sel == SRC_XTAL)) |-> (sel == SRC_MSI));
  p_wk_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mon_en && ((sel == SRC_XTAL) || (act == SRC_XTAL))) |-> $stable(wk));
endmodule

// File: rtl/sysclk_div_stage.sv
module sysclk_div_stage
  import sysclk_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned MAX_SH = 9,
  parameter bit          IS_CORE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_en,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic              out_en,
  output logic [CODE_W-1:0] applied
);
  localparam int unsigned CNT_W = (MAX_SH > 0) ? MAX_SH : 1;

  logic [CODE_W-1:0] pend, pend_d, app_d;
  logic [CNT_W-1:0]  cnt, cnt_d, lim;
  logic [3:0]        sh;
  logic              hit;

  generate
    if (IS_CORE) begin : g_core
      always_comb sh = core_shift(4'(applied));
    end else begin : g_per
      always_comb sh = per_shift(3'(applied));
    end
  endgenerate

  always_comb begin
    lim    = CNT_W'((32'd1 << sh) - 32'd1);
    hit    = in_en && (cnt == lim);
    out_en = hit;
    pend_d = wr_en ? wr_code : pend;
    app_d  = hit ? pend : applied;
    if (hit)        cnt_d = '0;
    else if (in_en) cnt_d = cnt + CNT_W'(1);
    else            cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      applied <= '0;
      cnt     <= '0;
    end else begin
      pend    <= pend_d;
      applied <= app_d;
      cnt     <= cnt_d;
    end
  end

  p_apply_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (applied != $past(applied)) |-> $past(out_en));
  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned RDY_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] src_tick,
  input  logic [5:0] src_rdy,
  input  logic       lp_exit,
  input  logic       xtal_fail,
  input  logic       mon_en,
  input  logic       src_we,
  input  logic [2:0] src_wdata,
  input  logic       core_we,
  input  logic [3:0] core_wdata,
  input  logic       per_we,
  input  logic [2:0] per_wdata,
  input  logic       wk_we,
  input  logic       wk_wdata,
  output logic [2:0] src_sel,
  output logic [2:0] src_act,
  output logic [3:0] core_div,
  output logic [2:0] per_div,
  output logic       wk_sel,
  output logic       sys_en,
  output logic       core_en,
  output logic       per_en
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  sysclk_src_switch #(.RDY_CYC(RDY_CYC)) u_sw (
    .clk(clk), .rst_n(rst_n_s), .src_rdy(src_rdy), .lp_exit(lp_exit),
    .xtal_fail(xtal_fail), .mon_en(mon_en), .src_we(src_we),
    .src_wdata(src_wdata), .wk_we(wk_we), .wk_wdata(wk_wdata),
    .sel(src_sel), .act(src_act), .wk(wk_sel)
  );

  assign sys_en = src_tick[src_act];

  sysclk_div_stage #(.CODE_W(4), .MAX_SH(9), .IS_CORE(1'b1)) u_core_div (
    .clk(clk), .rst_n(rst_n_s), .in_en(sys_en), .wr_en(core_we),
    .wr_code(core_wdata), .out_en(core_en), .applied(core_div)
  );

  sysclk_div_stage #(.CODE_W(3), .MAX_SH(4), .IS_CORE(1'b0)) u_per_div (
    .clk(clk), .rst_n(rst_n_s), .in_en(core_en), .wr_en(per_we),
    .wr_code(per_wdata), .out_en(per_en), .applied(per_div)
  );

  p_sys_follows_act_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    core_en |-> sys_en);
  p_per_needs_core_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    per_en |-> core_en);
endmodule

// File: tb/sysclk_ctrl_tb.sv
module sysclk_ctrl_tb;
  localparam int CLK_PER = 10;
  localparam int NVEC = 10;
  localparam int VC_CODE[NVEC]  = '{0, 7, 8, 9, 10, 11, 12, 13, 14, 15};
  localparam int VP_CODE[NVEC]  = '{0, 3, 4, 5, 6, 7, 0, 4, 0, 5};
  localparam int VC_RATIO[NVEC] = '{1, 1, 2, 4, 8, 16, 64, 128, 256, 512};
  localparam int VP_RATIO[NVEC] = '{1, 1, 2, 4, 8, 16, 1, 2, 1, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] src_tick = 6'h3f, src_rdy = 6'h3f;
  logic lp_exit = 0, xtal_fail = 0, mon_en = 0;
  logic src_we = 0, core_we = 0, per_we = 0, wk_we = 0, wk_wdata = 0;
  logic [2:0] src_wdata = 0, per_wdata = 0;
  logic [3:0] core_wdata = 0;
  logic [2:0] src_sel, src_act, per_div;
  logic [3:0] core_div;
  logic wk_sel, sys_en, core_en, per_en;
  int checks = 0, errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  sysclk_ctrl u_dut (.*);

  task automatic ck(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one-cycle write strobes driven after a rising edge
  task automatic wr_src(input logic [2:0] v);
    @(posedge clk); #1 src_we = 1; src_wdata = v;
    @(posedge clk); #1 src_we = 0;
  endtask

  // count cycles between two consecutive pulses of core (sel=0) or peripheral (sel=1)
  task automatic measure(input bit sel, output int n);
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!(sel ? per_en : core_en) && guard < 5000);
    n = 0;
    do begin @(negedge clk); n++; end while (!(sel ? per_en : core_en) && n < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_sim();
  end

  initial begin
    int n, g;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    ck(src_sel == 0 && src_act == 0, "R1 source fields", src_sel, 0);
    ck(core_div == 0 && per_div == 0 && wk_sel == 0, "R1 divider codes", core_div, 0);
    ck(core_en == 1 && per_en == 1, "R1 divide by 1", core_en, 1);

    // R7 R8 table walk
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1 core_we = 1; core_wdata = 4'(VC_CODE[i]); per_we = 1; per_wdata = 3'(VP_CODE[i]);
      @(posedge clk); #1 core_we = 0; per_we = 0;
      g = 0;
      while (!(core_div == 4'(VC_CODE[i]) && per_div == 3'(VP_CODE[i])) && g < 5000) begin
        @(negedge clk); g++;
      end
      measure(0, n);
      ck(n == VC_RATIO[i], "R7 core interval", n, VC_RATIO[i]);
      measure(1, n);
      ck(n == VC_RATIO[i] * VP_RATIO[i], "R8 peripheral interval", n, VC_RATIO[i] * VP_RATIO[i]);
    end

    // R9 pending code waits for boundary
    @(posedge clk); #1 core_we = 1; core_wdata = 4'd9; per_we = 1; per_wdata = 3'd0;
    @(posedge clk); #1 core_we = 0; per_we = 0;
    g = 0;
    while (core_div != 4'd9 && g < 5000) begin @(negedge clk); g++; end
    do @(negedge clk); while (!core_en);
    n = 0;
    do begin
      @(posedge clk); #1 core_we = (n == 0); core_wdata = 4'd8;
      @(negedge clk); n++;
      if (n == 1) ck(core_div == 9, "R9 old readback held", core_div, 9);
    end while (!core_en && n < 100);
    #1 core_we = 0;
    ck(n == 4, "R9 running interval kept", n, 4);
    @(negedge clk);
    ck(core_div == 8, "R9 new readback at boundary", core_div, 8);
    n = 1;
    while (!core_en && n < 100) begin @(negedge clk); n++; end
    ck(n == 2, "R9 new interval", n, 2);

    // R2 reserved codes
    wr_src(3'd6); @(negedge clk);
    ck(src_sel == 0, "R2 reserved 6 ignored", src_sel, 0);
    wr_src(3'd3); @(negedge clk);
    ck(src_sel == 3, "R2 code 3 taken", src_sel, 3);
    wr_src(3'd7); @(negedge clk);
    ck(src_sel == 3, "R2 reserved 7 ignored", src_sel, 3);
    repeat (6) @(negedge clk);

    // R3 ready qualification timing
    @(posedge clk); #1 src_we = 1; src_wdata = 3'd1;
    @(posedge clk); #1 src_we = 0;
    for (int j = 1; j <= 5; j++) begin
      @(negedge clk);
      if (j == 4) ck(src_act == 3, "R3 status held before qualify", src_act, 3);
      if (j == 5) ck(src_act == 1, "R3 status after qualify", src_act, 1);
    end
    src_rdy[2] = 1'b0;
    wr_src(3'd2);
    repeat (10) @(negedge clk);
    ck(src_act == 1 && src_sel == 2, "R3 not ready keeps status", src_act, 1);
    #1 src_rdy[2] = 1'b1;
    repeat (6) @(negedge clk);
    ck(src_act == 2, "R3 status after ready", src_act, 2);

    // R4 system enable follows active source tick
    for (int j = 0; j < 6; j++) begin
      @(posedge clk); #1 src_tick = (j % 2) ? 6'b000100 : 6'b111011;
      @(negedge clk);
      ck(sys_en == src_tick[2], "R4 sys_en tracks source 2", sys_en, src_tick[2]);
    end
    @(posedge clk); #1 src_tick = 6'h3f;

    // R10 wake select lock
    mon_en = 1;
    @(posedge clk); #1 wk_we = 1; wk_wdata = 1;
    @(posedge clk); #1 wk_we = 0;
    @(negedge clk);
    ck(wk_sel == 0, "R10 locked write ignored", wk_sel, 0);
    mon_en = 0;
    @(posedge clk); #1 wk_we = 1; wk_wdata = 1;
    @(posedge clk); #1 wk_we = 0;
    @(negedge clk);
    ck(wk_sel == 1, "R10 unlocked write taken", wk_sel, 1);

    // R6 crystal failure
    @(posedge clk); #1 xtal_fail = 1;
    @(posedge clk); #1 xtal_fail = 0;
    @(negedge clk);
    ck(src_sel == 0, "R6 failure forces 0", src_sel, 0);
    wr_src(3'd1);
    @(posedge clk); #1 xtal_fail = 1;
    @(posedge clk); #1 xtal_fail = 0;
    @(negedge clk);
    ck(src_sel == 1, "R6 failure ignored off crystal", src_sel, 1);

    // R5 wake-up beats same-cycle write
    @(posedge clk); #1 lp_exit = 1; src_we = 1; src_wdata = 3'd3;
    @(posedge clk); #1 lp_exit = 0; src_we = 0;
    @(negedge clk);
    ck(src_sel == 0, "R5 wake-up override", src_sel, 0);

    // R1 reset mid-run
    wr_src(3'd4);
    @(posedge clk); #1 core_we = 1; core_wdata = 4'd10;
    @(posedge clk); #1 core_we = 0;
    repeat (20) @(negedge clk);
    #1 rst_n = 0;
    #1;
    ck(src_sel == 0 && src_act == 0 && wk_sel == 0, "R1 async reset fields", src_sel, 0);
    ck(core_div == 0 && per_div == 0, "R1 async reset codes", core_div, 0);
    finish_sim();
  end
endmodule